// File: doc/BRIEF.md
# Frame-Capture DMA Controller

This block moves image data from a capture device into memory without processor involvement. Software programs it through a small register port. It stages an argument value and applies it with command codes: set the destination buffer, set the number of frames, power the device on or off, enable or disable the interrupt, and latch camera positioning values. It then writes the start bit. Once started, the engine accepts 32-bit words from the device stream with a ready/valid handshake. It writes each word to memory at an address that advances by four bytes per word, and it counts frames of a fixed word length.

When the last word of the last frame has been written, the engine leaves the busy state and raises a done flag. If the device is stopped while a transfer is in flight, the transfer is abandoned and an aborted flag is raised. A fault from the device during a transfer raises an error flag. Starting while the device is off also raises the error flag. The three outcome flags are cleared by writing ones to them. Any of them drives the interrupt line while the interrupt is enabled. A stall from the memory side holds the stream handshake off, so no word is lost.

Top module: `frame_dma`

## Requirements
- R1: After reset, the status reads zero, the interrupt enable, frame count, buffer address and staged argument read zero, `streamReady` and `memWrEn` are low and `irq` is low.
- R2: Command 3 copies the staged argument (register 3) into the buffer address, and command 4 copies its low frame-count bits into the frame count, but only while not busy; while busy both commands leave the values unchanged.
- R3: Writing 1 to bit 0 of register 1 while idle, with the device on and a nonzero frame count, sets busy (status bit 0); `streamReady` is high exactly while busy and `memStall` is low.
- R4: Each accepted stream word (`streamValid` and `streamReady` both high) is presented the same cycle on `memWrEn`/`memData` at the current buffer address, and the address then advances by 4.
- R5: The frame count drops by one after every FRAME_WORDS accepted words; when the final word of the last frame is accepted, busy clears and done (status bit 1) sets the next cycle.
- R6: Starting with a frame count of zero sets done at once, leaves busy low and produces no memory write.
- R7: Starting while the device is off (status bit 4 low) sets error (status bit 2) and no transfer begins.
- R8: Command 2 (device off) while busy clears busy, sets aborted (status bit 3) and allows no further memory writes; the frame count keeps its progress.
- R9: `devFault` high while busy clears busy and sets error.
- R10: While `memStall` is high, `streamReady` and `memWrEn` stay low, and every word eventually offered is written once.
- R11: Writing register 0 clears each of done, error and aborted whose bit is 1 in the written value; other writes leave them set.
- R12: `irq` is high exactly while the interrupt enable is set (command 5 sets it, command 6 clears it, read at register 1 bit 0) and at least one of done, error or aborted is set.
- R13: A start written while busy is ignored; the transfer continues without restarting.
- R14: Commands 7, 8 and 9 latch the low byte of the staged argument as pan, tilt and zoom, readable at register 2 in bits 7:0, 15:8 and 23:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 3 | Register select (0 status, 1 start/irq enable, 2 command/optics, 3 argument, 4 address, 5 frames) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regSel` |
| streamValid | input | 1 | Device stream word valid |
| streamData | input | DATA_W | Device stream word |
| streamReady | output | 1 | Engine accepts a stream word |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory byte address |
| memData | output | DATA_W | Memory write data |
| memStall | input | 1 | Memory cannot take a write this cycle |
| devFault | input | 1 | Device reports a fault |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with FRAME_WORDS of 4 and an 8-bit frame counter. At that size, multi-frame completion, mid-frame aborts and faults each take only a few dozen cycles. The small frame length makes frame boundaries frequent, so stalls placed on a fixed pattern land both inside frames and on their final words. Commands issued mid-transfer are seen against a frame count that is actively changing.

// File: rtl/frame_dma_pkg.sv
package frame_dma_pkg;

  localparam int REG_W = 32;

  // register selects
  localparam logic [2:0] SEL_STATUS = 3'd0;
  localparam logic [2:0] SEL_GO     = 3'd1;
  localparam logic [2:0] SEL_CMD    = 3'd2;
  localparam logic [2:0] SEL_ARG    = 3'd3;
  localparam logic [2:0] SEL_ADDR   = 3'd4;
  localparam logic [2:0] SEL_FRAMES = 3'd5;

  // command codes
  localparam logic [3:0] OP_DEV_ON     = 4'd1;
  localparam logic [3:0] OP_DEV_OFF    = 4'd2;
  localparam logic [3:0] OP_SET_BUF    = 4'd3;
  localparam logic [3:0] OP_SET_FRAMES = 4'd4;
  localparam logic [3:0] OP_IRQ_ON     = 4'd5;
  localparam logic [3:0] OP_IRQ_OFF    = 4'd6;
  localparam logic [3:0] OP_PAN        = 4'd7;
  localparam logic [3:0] OP_TILT       = 4'd8;
  localparam logic [3:0] OP_ZOOM       = 4'd9;

  // status bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_ABT  = 3;
  localparam int ST_DEV  = 4;

  typedef struct packed {
    logic loadBuf;
    logic loadFrames;
    logic clrWord;
    logic acceptWord;
  } dp_strobe_t;

endpackage

// File: rtl/frame_dma_dpath.sv
module frame_dma_dpath
  import frame_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int FRAME_CNT_W = 16,
  parameter int FRAME_WORDS = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dp_strobe_t             stb,
  input  logic [ADDR_W-1:0]      loadVal,
  input  logic [DATA_W-1:0]      streamData,
  output logic [ADDR_W-1:0]      curAddr,
  output logic [FRAME_CNT_W-1:0] framesLeft,
  output logic [DATA_W-1:0]      memData,
  output logic                   lastBeat,
  output logic                   framesZero
);

  localparam int WORD_CNT_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [WORD_CNT_W-1:0] LAST_WORD = WORD_CNT_W'(FRAME_WORDS - 1);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(DATA_W / 8);
  localparam logic [FRAME_CNT_W-1:0] ONE_FRAME = FRAME_CNT_W'(1);

  logic [WORD_CNT_W-1:0] wordCnt;
  logic endOfFrame;

  assign endOfFrame = stb.acceptWord && (wordCnt == LAST_WORD);
  assign lastBeat   = (wordCnt == LAST_WORD) && (framesLeft == ONE_FRAME);
  assign framesZero = (framesLeft == '0);
  assign memData    = streamData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (stb.loadBuf) begin
      curAddr <= loadVal;
    end else if (stb.acceptWord) begin
      curAddr <= curAddr + ADDR_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      framesLeft <= '0;
    end else if (stb.loadFrames) begin
      framesLeft <= loadVal[FRAME_CNT_W-1:0];
    end else if (endOfFrame && !framesZero) begin
      framesLeft <= framesLeft - ONE_FRAME;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt <= '0;
    end else if (stb.clrWord) begin
      wordCnt <= '0;
    end else if (stb.acceptWord) begin
      wordCnt <= endOfFrame ? '0 : wordCnt + WORD_CNT_W'(1);
    end
  end

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.acceptWord && !stb.loadBuf) |=> (curAddr == $past(curAddr) + ADDR_STEP));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.acceptWord && !stb.loadBuf) |=> $stable(curAddr));

  // R2
  frames_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadFrames |=> (framesLeft <= $past(framesLeft)));

endmodule

// File: rtl/frame_dma_ctrl.sv
module frame_dma_ctrl
  import frame_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int FRAME_CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWr,
  input  logic [2:0]             regSel,
  input  logic [REG_W-1:0]       regWdata,
  output logic [REG_W-1:0]       regRdata,
  input  logic                   streamValid,
  input  logic                   memStall,
  input  logic                   devFault,
  output logic                   streamReady,
  output logic                   memWrEn,
  output logic                   irq,
  output dp_strobe_t             stb,
  output logic [ADDR_W-1:0]      loadVal,
  input  logic [ADDR_W-1:0]      curAddr,
  input  logic [FRAME_CNT_W-1:0] framesLeft,
  input  logic                   lastBeat,
  input  logic                   framesZero
);

  logic busyQ, doneQ, errQ, abtQ, devOnQ, irqEnQ;
  logic [REG_W-1:0] argQ;
  logic [7:0] panQ, tiltQ, zoomQ;

  logic wrStatus, goHit, cmdHit, stopHit, accept;
  logic abortNow, faultNow, doneNow;
  logic startOk, goErr, goEmpty;
  logic [3:0] op;

  assign op       = regWdata[3:0];
  assign wrStatus = regWr && (regSel == SEL_STATUS);
  assign goHit    = regWr && (regSel == SEL_GO) && regWdata[0];
  assign cmdHit   = regWr && (regSel == SEL_CMD);
  assign stopHit  = cmdHit && (op == OP_DEV_OFF);

  assign accept   = busyQ && streamValid && !memStall;
  assign abortNow = busyQ && stopHit;
  assign faultNow = busyQ && devFault && !stopHit;
  assign doneNow  = busyQ && accept && lastBeat && !stopHit && !devFault;

  assign startOk  = goHit && !busyQ && devOnQ && !framesZero;
  assign goErr    = goHit && !busyQ && !devOnQ;
  assign goEmpty  = goHit && !busyQ && devOnQ && framesZero;

  always_comb begin
    stb.loadBuf    = cmdHit && (op == OP_SET_BUF) && !busyQ;
    stb.loadFrames = cmdHit && (op == OP_SET_FRAMES) && !busyQ;
    stb.clrWord    = startOk;
    stb.acceptWord = accept;
  end

  assign loadVal     = argQ[ADDR_W-1:0];
  assign streamReady = busyQ && !memStall;
  assign memWrEn     = accept;
  assign irq         = irqEnQ && (doneQ || errQ || abtQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (startOk) begin
      busyQ <= 1'b1;
    end else if (abortNow || faultNow || doneNow) begin
      busyQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      abtQ  <= 1'b0;
    end else begin
      doneQ <= (doneQ && !(wrStatus && regWdata[ST_DONE])) || doneNow || goEmpty;
      errQ  <= (errQ && !(wrStatus && regWdata[ST_ERR])) || faultNow || goErr;
      abtQ  <= (abtQ && !(wrStatus && regWdata[ST_ABT])) || abortNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devOnQ <= 1'b0;
      irqEnQ <= 1'b0;
      panQ   <= '0;
      tiltQ  <= '0;
      zoomQ  <= '0;
    end else if (cmdHit) begin
      case (op)
        OP_DEV_ON:  devOnQ <= 1'b1;
        OP_DEV_OFF: devOnQ <= 1'b0;
        OP_IRQ_ON:  irqEnQ <= 1'b1;
        OP_IRQ_OFF: irqEnQ <= 1'b0;
        OP_PAN:     panQ   <= argQ[7:0];
        OP_TILT:    tiltQ  <= argQ[7:0];
        OP_ZOOM:    zoomQ  <= argQ[7:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      argQ <= '0;
    end else if (regWr && (regSel == SEL_ARG)) begin
      argQ <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_STATUS: begin
        regRdata[ST_BUSY] = busyQ;
        regRdata[ST_DONE] = doneQ;
        regRdata[ST_ERR]  = errQ;
        regRdata[ST_ABT]  = abtQ;
        regRdata[ST_DEV]  = devOnQ;
      end
      SEL_GO:     regRdata[0] = irqEnQ;
      SEL_CMD:    regRdata[23:0] = {zoomQ, tiltQ, panQ};
      SEL_ARG:    regRdata = argQ;
      SEL_ADDR:   regRdata = REG_W'(curAddr);
      SEL_FRAMES: regRdata = REG_W'(framesLeft);
      default:    regRdata = '0;
    endcase
  end

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> (doneQ || errQ || abtQ));

  // R3
  start_frames_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> !framesZero);

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abtQ) |-> !memWrEn);

endmodule

// File: rtl/frame_dma.sv
module frame_dma
  import frame_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int FRAME_CNT_W = 16,
  parameter int FRAME_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              streamValid,
  input  logic [DATA_W-1:0] streamData,
  output logic              streamReady,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memStall,
  input  logic              devFault,
  output logic              irq
);

  dp_strobe_t             stb;
  logic [ADDR_W-1:0]      loadVal;
  logic [ADDR_W-1:0]      curAddr;
  logic [FRAME_CNT_W-1:0] framesLeft;
  logic                   lastBeat;
  logic                   framesZero;

  frame_dma_ctrl #(
    .ADDR_W     (ADDR_W),
    .FRAME_CNT_W(FRAME_CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regSel     (regSel),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .streamValid(streamValid),
    .memStall   (memStall),
    .devFault   (devFault),
    .streamReady(streamReady),
    .memWrEn    (memWrEn),
    .irq        (irq),
    .stb        (stb),
    .loadVal    (loadVal),
    .curAddr    (curAddr),
    .framesLeft (framesLeft),
    .lastBeat   (lastBeat),
    .framesZero (framesZero)
  );

  frame_dma_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .FRAME_CNT_W(FRAME_CNT_W),
    .FRAME_WORDS(FRAME_WORDS)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .loadVal    (loadVal),
    .streamData (streamData),
    .curAddr    (curAddr),
    .framesLeft (framesLeft),
    .memData    (memData),
    .lastBeat   (lastBeat),
    .framesZero (framesZero)
  );

  assign memAddr = curAddr;

endmodule

// File: tb/test_frame_dma.sv
module test_frame_dma;

  localparam int FW  = 4;
  localparam int FCW = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regSel = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        streamValid = 1'b0;
  logic [31:0] streamData = '0;
  logic        streamReady;
  logic        memWrEn;
  logic [31:0] memAddr;
  logic [31:0] memData;
  logic        memStall = 1'b0;
  logic        devFault = 1'b0;
  logic        irq;

  frame_dma #(
    .ADDR_W(32), .DATA_W(32), .FRAME_CNT_W(FCW), .FRAME_WORDS(FW)
  ) i_frame_dma (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .streamValid(streamValid),
    .streamData(streamData), .streamReady(streamReady), .memWrEn(memWrEn),
    .memAddr(memAddr), .memData(memData), .memStall(memStall),
    .devFault(devFault), .irq(irq)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int wrCount = 0;
  bit finished = 0;

  // reference model state
  bit mBusy, mDone, mErr, mAbt, mDev, mIrqEn;
  logic [31:0] mArg, mAddr;
  int mFrames, mWord;
  logic [7:0] mPan, mTilt, mZoom;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mBusy = 0; mDone = 0; mErr = 0; mAbt = 0; mDev = 0; mIrqEn = 0;
    mArg = '0; mAddr = '0; mFrames = 0; mWord = 0;
    mPan = '0; mTilt = '0; mZoom = '0;
  endtask

  // one clock: compare outputs with the model, then advance the model
  task automatic cyc();
    bit acc, expReady, expIrq, fin, wrS, go, cmd;
    logic [31:0] expRd;
    logic [3:0] op;
    bit nBusy, nDone, nErr, nAbt, nDev, nIrqEn;
    logic [31:0] nArg, nAddr;
    int nFrames, nWord;
    logic [7:0] nPan, nTilt, nZoom;
    #1;
    acc = mBusy && streamValid && !memStall;
    expReady = mBusy && !memStall;
    expIrq = mIrqEn && (mDone || mErr || mAbt);
    case (regSel)
      3'd0: expRd = {27'd0, mDev, mAbt, mErr, mDone, mBusy};
      3'd1: expRd = {31'd0, mIrqEn};
      3'd2: expRd = {8'd0, mZoom, mTilt, mPan};
      3'd3: expRd = mArg;
      3'd4: expRd = mAddr;
      3'd5: expRd = 32'(mFrames);
      default: expRd = '0;
    endcase
    chk(streamReady === expReady, "R10 streamReady", 32'(streamReady), 32'(expReady));
    chk(memWrEn === acc, "R4 memWrEn", 32'(memWrEn), 32'(acc));
    if (acc) begin
      chk(memAddr === mAddr, "R4 memAddr", memAddr, mAddr);
      chk(memData === streamData, "R4 memData", memData, streamData);
    end
    chk(irq === expIrq, "R12 irq", 32'(irq), 32'(expIrq));
    chk(regRdata === expRd, "R11 regRdata", regRdata, expRd);
    if (memWrEn === 1'b1) wrCount++;

    nBusy = mBusy; nDone = mDone; nErr = mErr; nAbt = mAbt; nDev = mDev;
    nIrqEn = mIrqEn; nArg = mArg; nAddr = mAddr; nFrames = mFrames;
    nWord = mWord; nPan = mPan; nTilt = mTilt; nZoom = mZoom;
    fin = 0;
    if (acc) begin
      nAddr = mAddr + 32'd4;
      if (mWord == FW - 1) begin
        nWord = 0;
        if (mFrames > 0) nFrames = mFrames - 1;
        fin = (mFrames == 1);
      end else begin
        nWord = mWord + 1;
      end
    end
    wrS = regWr && regSel == 3'd0;
    go  = regWr && regSel == 3'd1 && regWdata[0];
    cmd = regWr && regSel == 3'd2;
    op  = regWdata[3:0];
    if (wrS) begin
      if (regWdata[1]) nDone = 0;
      if (regWdata[2]) nErr = 0;
      if (regWdata[3]) nAbt = 0;
    end
    if (regWr && regSel == 3'd3) nArg = regWdata;
    if (cmd) begin
      case (op)
        4'd1: nDev = 1;
        4'd2: nDev = 0;
        4'd3: if (!mBusy) nAddr = mArg;
        4'd4: if (!mBusy) nFrames = int'(mArg[FCW-1:0]);
        4'd5: nIrqEn = 1;
        4'd6: nIrqEn = 0;
        4'd7: nPan = mArg[7:0];
        4'd8: nTilt = mArg[7:0];
        4'd9: nZoom = mArg[7:0];
        default: ;
      endcase
    end
    if (mBusy) begin
      if (cmd && op == 4'd2) begin nBusy = 0; nAbt = 1; end
      else if (devFault) begin nBusy = 0; nErr = 1; end
      else if (fin) begin nBusy = 0; nDone = 1; end
    end else if (go) begin
      if (!mDev) nErr = 1;
      else if (mFrames == 0) nDone = 1;
      else begin nBusy = 1; nWord = 0; end
    end
    @(posedge clk);
    mBusy = nBusy; mDone = nDone; mErr = nErr; mAbt = nAbt; mDev = nDev;
    mIrqEn = nIrqEn; mArg = nArg; mAddr = nAddr; mFrames = nFrames;
    mWord = nWord; mPan = nPan; mTilt = nTilt; mZoom = nZoom;
    #2;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    regSel = sel; regWdata = d; regWr = 1'b1;
    cyc();
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] v);
    regSel = sel;
    #1;
    v = regRdata;
  endtask

  // stream until the model leaves busy; optional stalls and mid-run pokes
  task automatic feed(input bit stalls, input bit poke);
    logic [31:0] dataCtr = 32'hA000_0000;
    for (int i = 0; i < 200 && mBusy; i++) begin
      streamValid = 1'b1;
      streamData = dataCtr;
      memStall = stalls && ((i % 5 == 2) || (i % 5 == 3));
      regWr = 1'b0;
      if (poke && i == 3) begin regWr = 1'b1; regSel = 3'd1; regWdata = 32'd1; end
      if (poke && i == 6) begin regWr = 1'b1; regSel = 3'd2; regWdata = 32'd3; end
      if (mBusy && !memStall) dataCtr = dataCtr + 32'd1;
      cyc();
    end
    regWr = 1'b0; regWdata = '0; streamValid = 1'b0; memStall = 1'b0;
  endtask

  task automatic feedN(input int n);
    int got = 0;
    for (int i = 0; i < 100 && got < n; i++) begin
      streamValid = 1'b1;
      streamData = 32'hB000_0000 + 32'(i);
      if (mBusy) got++;
      cyc();
    end
    streamValid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    modelReset();
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk(v == 32'h0, "R1 status after reset", v, 32'h0);
    rd(3'd5, v); chk(v == 32'h0, "R1 frames after reset", v, 32'h0);
    rd(3'd4, v); chk(v == 32'h0, "R1 address after reset", v, 32'h0);
    chk(streamReady == 1'b0 && irq == 1'b0, "R1 outputs idle", {30'd0, streamReady, irq}, 32'h0);
    cyc();

    // R7 start with device off
    wr(3'd1, 32'd1);
    rd(3'd0, v); chk(v == 32'h4, "R7 error on start while off", v, 32'h4);
    // R11 write-one-to-clear, non-matching bits leave it
    wr(3'd0, 32'h2);
    rd(3'd0, v); chk(v == 32'h4, "R11 unrelated clear keeps error", v, 32'h4);
    wr(3'd0, 32'h4);
    rd(3'd0, v); chk(v == 32'h0, "R11 error cleared", v, 32'h0);

    // R2 program buffer and frames
    wr(3'd2, 32'd5);
    wr(3'd2, 32'd1);
    wr(3'd3, 32'h0000_1000);
    wr(3'd2, 32'd3);
    wr(3'd3, 32'd2);
    wr(3'd2, 32'd4);
    rd(3'd4, v); chk(v == 32'h1000, "R2 buffer loaded", v, 32'h1000);
    rd(3'd5, v); chk(v == 32'd2, "R2 frames loaded", v, 32'd2);

    // R3 start, R4/R5/R10/R13 run with stalls and mid-run commands
    wr(3'd1, 32'd1);
    rd(3'd0, v); chk(v == 32'h11, "R3 busy after start", v, 32'h11);
    chk(streamReady == 1'b1, "R3 ready while busy", 32'(streamReady), 32'h1);
    wrCount = 0;
    feed(1'b1, 1'b1);
    chk(wrCount == 2 * FW, "R10 every word written once", 32'(wrCount), 32'(2 * FW));
    rd(3'd4, v); chk(v == 32'h1020, "R13 R2 address shows no restart or reload", v, 32'h1020);
    rd(3'd5, v); chk(v == 32'd0, "R5 frames exhausted", v, 32'd0);
    rd(3'd0, v); chk(v == 32'h12, "R5 done set, busy clear", v, 32'h12);
    chk(irq == 1'b1, "R12 irq on done", 32'(irq), 32'h1);
    wr(3'd2, 32'd6);
    chk(irq == 1'b0, "R12 irq masked", 32'(irq), 32'h0);
    rd(3'd1, v); chk(v == 32'h0, "R12 enable cleared", v, 32'h0);
    wr(3'd0, 32'h2);

    // R6 zero-frame start
    wr(3'd3, 32'd0);
    wr(3'd2, 32'd4);
    streamValid = 1'b1;
    wrCount = 0;
    wr(3'd1, 32'd1);
    cyc();
    streamValid = 1'b0;
    rd(3'd0, v); chk(v == 32'h12, "R6 done without busy", v, 32'h12);
    chk(wrCount == 0, "R6 no memory writes", 32'(wrCount), 32'h0);
    wr(3'd0, 32'h2);

    // R8 abort mid-transfer
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd3);
    wr(3'd2, 32'd4);
    wr(3'd1, 32'd1);
    feedN(5);
    wr(3'd2, 32'd2);
    rd(3'd0, v); chk(v == 32'h08, "R8 aborted, busy and device clear", v, 32'h08);
    rd(3'd5, v); chk(v == 32'd2, "R8 frame progress kept", v, 32'd2);
    chk(irq == 1'b1, "R12 irq on abort", 32'(irq), 32'h1);
    streamValid = 1'b1;
    wrCount = 0;
    cyc(); cyc();
    streamValid = 1'b0;
    chk(wrCount == 0 && streamReady == 1'b0, "R8 no writes after abort", 32'(wrCount), 32'h0);
    wr(3'd0, 32'h8);

    // R9 device fault
    wr(3'd2, 32'd1);
    wr(3'd3, 32'd1);
    wr(3'd2, 32'd4);
    wr(3'd1, 32'd1);
    feedN(2);
    devFault = 1'b1;
    cyc();
    devFault = 1'b0;
    rd(3'd0, v); chk(v == 32'h14, "R9 error after fault", v, 32'h14);
    rd(3'd5, v); chk(v == 32'd1, "R9 frame not finished", v, 32'd1);
    wr(3'd0, 32'h4);

    // R14 optics latches
    wr(3'd3, 32'h0000_015A); wr(3'd2, 32'd7);
    wr(3'd3, 32'h0000_0033); wr(3'd2, 32'd8);
    wr(3'd3, 32'h0000_00C4); wr(3'd2, 32'd9);
    rd(3'd2, v); chk(v == 32'h00C4_335A, "R14 optics bytes", v, 32'h00C4_335A);
    cyc();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule